// File: doc/BRIEF.md
# Dual-Rate Streaming Multiplier Array

This block turns a stream of wide beats of packed unsigned operands into a stream of wide beats of 64-bit products. Beats enter and leave on a fast clock, and both sides use valid/ready handshakes. The multiplication runs on a second clock at half the fast rate. That clock comes from the same source and is phase-aligned, so every half-rate rising edge falls on a fast rising edge. Within each ingress beat, words are taken two at a time in word order. Two consecutive ingress beats supply one operand pair to each lane of a bank of pipelined multipliers, and the bank advances once per half-rate cycle.

Each half-rate step produces twice as many products as one egress beat can carry. The results are therefore split into two fast-clock egress beats. Since two beats arrive and two beats leave per half-rate cycle, the block keeps up with a full-rate input stream. When the egress side stalls, the multiplier pipeline freezes and ingress ready falls, so no data is dropped.

The fast domain works out locally which of its edges coincide with half-rate edges. It does this by watching a toggle bit that the half-rate domain flips on every edge. The block accepts no data until it has seen that phase once after reset.

Top module: `dual_rate_mul_array`

## Requirements
- R1: While rst_n is low, in_ready and out_valid are low from the next fast edge on.
- R2: Every product is the unsigned 64-bit product of ingress words 2k and 2k+1 of one beat, where word w sits at bits [32w+31:32w].
- R3: Ingress beats are grouped in consecutive pairs. Egress beat j (first, then second) of a group carries the products of ingress beat j of that group, and the product of pair k sits at bits [64k+63:64k].
- R4: Under random stalls on both handshakes, every product leaves exactly once and in ingress order.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data is unchanged at the next fast edge.
- R6: With out_ready held high and a beat offered on every fast cycle, in_ready never drops once the block runs, and egress beats leave on consecutive fast cycles.
- R7: With out_ready held low, ingress stops after at most 13 accepted beats (default parameters) and in_ready stays low. All held data is delivered once out_ready rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Stream clock for ingress and egress |
| clk_half | input | 1 | Half-rate multiplier clock, rising edges aligned to every other clk_fast edge |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clocks |
| in_valid | input | 1 | Ingress beat offered |
| in_ready | output | 1 | Ingress beat accepted on this fast edge when valid |
| in_data | input | BEAT_W (256) | Packed operand words, word 0 in the low bits |
| out_valid | output | 1 | Egress beat offered |
| out_ready | input | 1 | Downstream accepts the egress beat |
| out_data | output | BEAT_W (256) | Packed 64-bit products, earliest product in the low lane |

## Verification
The bench builds the block with its default parameters: 256-bit beats, 32-bit operands and four multiplier stages. This gives four pairs per beat and eight lanes, so a full stall buffers thirteen beats, and the R7 bound can be reached and checked within a short stall window. A fixed table of corner operands (all ones, zero, one, the top bit alone) checks the lane positions against precomputed products. A randomized stream with random valid and ready then checks ordering and exactly-once delivery against a model of 64-bit multiplication.

// File: rtl/drm_pkg.sv
package drm_pkg;
    localparam int unsigned DEF_BEAT_W = 256;
    localparam int unsigned DEF_OP_W   = 32;
    localparam int unsigned DEF_STAGES = 4;

    // Which half of a two-beat group a gearbox is working on.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;
endpackage

// File: rtl/drm_phase_track.sv
// Learns, in the fast domain, which fast edges coincide with half-rate edges.
module drm_phase_track (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic tog_half,
    output logic locked,
    output logic hedge
);
    typedef struct packed {
        logic seen;
        logic lock;
    } trk_t;

    trk_t trk_d, trk_q;
    logic mid;

    // The toggle flips on each half edge; until the fast side has copied it,
    // the fast cycle in progress ends between two half edges.
    assign mid    = tog_half ^ trk_q.seen;
    assign locked = trk_q.lock;
    assign hedge  = trk_q.lock && !mid;

    always_comb begin
        trk_d      = trk_q;
        trk_d.seen = tog_half;
        if (mid) trk_d.lock = 1'b1;
    end

    always_ff @(posedge clk_fast) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // R6: once locked, half edges and mid edges alternate
    assert_hedge_alternates_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        hedge |=> !hedge);
    assert_mid_then_hedge_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (locked && !hedge) |=> hedge);
endmodule

// File: rtl/drm_ingress.sv
// Gathers two ingress beats into one operand group for the multiplier bank.
module drm_ingress
    import drm_pkg::*;
#(
    parameter int unsigned BEAT_W = DEF_BEAT_W
) (
    input  logic                  clk_fast,
    input  logic                  rst_n,
    input  logic                  locked,
    input  logic                  take,
    input  logic                  in_valid,
    input  logic [BEAT_W-1:0]     in_data,
    output logic                  in_ready,
    output logic [2*BEAT_W-1:0]   grp,
    output logic                  grp_v
);
    localparam int unsigned GRP_W = 2 * BEAT_W;

    typedef struct packed {
        logic [BEAT_W-1:0] low;
        half_sel_e         slot;
        logic [GRP_W-1:0]  grp;
        logic              grp_v;
    } ing_t;

    ing_t ing_d, ing_q;
    logic grp_free;
    logic fire;

    assign grp_free = !ing_q.grp_v || take;
    assign in_ready = locked && ((ing_q.slot == HALF_LO) || grp_free);
    assign fire     = in_valid && in_ready;
    assign grp      = ing_q.grp;
    assign grp_v    = ing_q.grp_v;

    always_comb begin
        ing_d = ing_q;
        if (take) ing_d.grp_v = 1'b0;
        if (fire) begin
            if (ing_q.slot == HALF_LO) begin
                ing_d.low  = in_data;
                ing_d.slot = HALF_HI;
            end else begin
                ing_d.grp   = {in_data, ing_q.low};
                ing_d.grp_v = 1'b1;
                ing_d.slot  = HALF_LO;
            end
        end
    end

    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            ing_q.low   <= '0;
            ing_q.slot  <= HALF_LO;
            ing_q.grp   <= '0;
            ing_q.grp_v <= 1'b0;
        end else begin
            ing_q <= ing_d;
        end
    end

    // R1: no acceptance out of reset
    assert_ready_low_in_reset_R1: assert property (@(posedge clk_fast)
        !rst_n |=> !in_ready);
    // R4: a waiting group is neither lost nor overwritten
    assert_group_held_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (grp_v && !take) |=> (grp_v && $stable(grp)));
endmodule

// File: rtl/drm_mul_lane.sv
// One pipelined unsigned multiplier; advances only when enabled.
module drm_mul_lane #(
    parameter int unsigned OP_W   = 32,
    parameter int unsigned STAGES = 4
) (
    input  logic              clk,
    input  logic              en,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] p
);
    localparam int unsigned PW = 2 * OP_W;

    logic [PW-1:0] pipe_d [STAGES];
    logic [PW-1:0] pipe_q [STAGES];

    always_comb begin
        for (int s = 0; s < STAGES; s++) pipe_d[s] = pipe_q[s];
        if (en) begin
            pipe_d[0] = PW'(a) * PW'(b);
            for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) pipe_q[s] <= pipe_d[s];
    end

    assign p = pipe_q[STAGES-1];
endmodule

// File: rtl/drm_mul_pipe.sv
// Half-rate multiplier bank with a shared valid chain and phase toggle.
module drm_mul_pipe
    import drm_pkg::*;
#(
    parameter int unsigned BEAT_W = DEF_BEAT_W,
    parameter int unsigned OP_W   = DEF_OP_W,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic                clk_half,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [2*BEAT_W-1:0] grp,
    input  logic                grp_v,
    output logic [2*BEAT_W-1:0] res,
    output logic                res_v,
    output logic                tog
);
    localparam int unsigned LANES = BEAT_W / OP_W;
    localparam int unsigned PW    = 2 * OP_W;

    typedef struct packed {
        logic [STAGES-1:0] v;
        logic              tog;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        drm_mul_lane #(.OP_W(OP_W), .STAGES(STAGES)) u_lane (
            .clk (clk_half),
            .en  (adv),
            .a   (grp[ln*PW +: OP_W]),
            .b   (grp[ln*PW+OP_W +: OP_W]),
            .p   (res[ln*PW +: PW])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.tog = ~ctl_q.tog;
        if (adv) ctl_d.v = {ctl_q.v[STAGES-2:0], grp_v};
    end

    always_ff @(posedge clk_half) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign res_v = ctl_q.v[STAGES-1];
    assign tog   = ctl_q.tog;

    // R4: a frozen pipeline keeps every valid slot
    assert_pipe_frozen_R4: assert property (@(posedge clk_half) disable iff (!rst_n)
        !adv |=> $stable(ctl_q.v));
    // R4: the output slot is only refilled when the pipeline steps
    assert_result_held_R4: assert property (@(posedge clk_half) disable iff (!rst_n)
        (res_v && !adv) |=> (res_v && $stable(res)));
endmodule

// File: rtl/drm_egress.sv
// Holds one multiplier result group and sends it as two fast beats.
module drm_egress
    import drm_pkg::*;
#(
    parameter int unsigned BEAT_W = DEF_BEAT_W
) (
    input  logic                clk_fast,
    input  logic                rst_n,
    input  logic                hedge,
    input  logic [2*BEAT_W-1:0] res,
    input  logic                res_v,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [BEAT_W-1:0]   out_data,
    output logic                adv
);
    localparam int unsigned GRP_W = 2 * BEAT_W;

    typedef struct packed {
        logic [GRP_W-1:0] hold;
        logic             v;
        half_sel_e        sel;
    } egr_t;

    egr_t egr_d, egr_q;
    logic free;
    logic load;

    // Room for a new group once the last beat of the current one leaves.
    assign free      = !egr_q.v || ((egr_q.sel == HALF_HI) && out_ready);
    assign adv       = hedge && (!res_v || free);
    assign load      = adv && res_v;
    assign out_valid = egr_q.v;
    assign out_data  = (egr_q.sel == HALF_HI) ? egr_q.hold[BEAT_W +: BEAT_W]
                                              : egr_q.hold[0 +: BEAT_W];

    always_comb begin
        egr_d = egr_q;
        if (egr_q.v && out_ready) begin
            if (egr_q.sel == HALF_LO) begin
                egr_d.sel = HALF_HI;
            end else begin
                egr_d.sel = HALF_LO;
                egr_d.v   = 1'b0;
            end
        end
        if (load) begin
            egr_d.hold = res;
            egr_d.v    = 1'b1;
            egr_d.sel  = HALF_LO;
        end
    end

    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            egr_q.hold <= '0;
            egr_q.v    <= 1'b0;
            egr_q.sel  <= HALF_LO;
        end else begin
            egr_q <= egr_d;
        end
    end

    // R1: nothing offered out of reset
    assert_valid_low_in_reset_R1: assert property (@(posedge clk_fast)
        !rst_n |=> !out_valid);
    // R5: an unaccepted beat stays put
    assert_beat_held_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dual_rate_mul_array.sv
module dual_rate_mul_array
    import drm_pkg::*;
#(
    parameter int unsigned BEAT_W = DEF_BEAT_W,
    parameter int unsigned OP_W   = DEF_OP_W,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic              clk_fast,
    input  logic              clk_half,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data
);
    localparam int unsigned GRP_W = 2 * BEAT_W;

    logic             tog;
    logic             locked;
    logic             hedge;
    logic             adv;
    logic [GRP_W-1:0] grp;
    logic             grp_v;
    logic [GRP_W-1:0] res;
    logic             res_v;

    drm_phase_track u_phase (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .tog_half (tog),
        .locked   (locked),
        .hedge    (hedge)
    );

    drm_ingress #(.BEAT_W(BEAT_W)) u_ingress (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .locked   (locked),
        .take     (adv),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .grp      (grp),
        .grp_v    (grp_v)
    );

    drm_mul_pipe #(.BEAT_W(BEAT_W), .OP_W(OP_W), .STAGES(STAGES)) u_pipe (
        .clk_half (clk_half),
        .rst_n    (rst_n),
        .adv      (adv),
        .grp      (grp),
        .grp_v    (grp_v),
        .res      (res),
        .res_v    (res_v),
        .tog      (tog)
    );

    drm_egress #(.BEAT_W(BEAT_W)) u_egress (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .hedge     (hedge),
        .res       (res),
        .res_v     (res_v),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .adv       (adv)
    );
endmodule

// File: tb/dual_rate_mul_array_tb.sv
module dual_rate_mul_array_tb;
    localparam int BW = 256;
    localparam int NP = BW / 64;

    logic clk_fast = 1'b0;
    logic clk_half = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [BW-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [BW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // operand a, operand b, expected product
    localparam logic [127:0] VECS [8] = '{
        {32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFE00000001},
        {32'h00000000, 32'hDEADBEEF, 64'h0000000000000000},
        {32'h00000001, 32'hCAFEF00D, 64'h00000000CAFEF00D},
        {32'h80000000, 32'h00000002, 64'h0000000100000000},
        {32'h00010000, 32'h00010000, 64'h0000000100000000},
        {32'h12345678, 32'h00000002, 64'h000000002468ACF0},
        {32'hFFFFFFFF, 32'h00000001, 64'h00000000FFFFFFFF},
        {32'h80000000, 32'h80000000, 64'h4000000000000000}
    };

    dual_rate_mul_array u_dut (
        .clk_fast  (clk_fast),
        .clk_half  (clk_half),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // 200 MHz fast clock; half-rate rises together with every other fast edge
    initial begin
        forever begin
            #2.5 clk_fast = 1'b1; clk_half = 1'b1;
            #2.5 clk_fast = 1'b0;
            #2.5 clk_fast = 1'b1; clk_half = 1'b0;
            #2.5 clk_fast = 1'b0;
        end
    end

    always @(posedge clk_fast) cyc++;

    logic [BW-1:0] exp_q[$];
    logic [BW-1:0] pend = '0;
    bit have_pend = 1'b0;
    int rdy_mode = 1;
    string cur_req = "R1";
    int acc_cnt = 0;
    int stall_cnt = 0;
    int out_cnt = 0;
    int first_out = -1;
    int last_out = 0;

    function automatic logic [BW-1:0] model(input logic [BW-1:0] b);
        logic [BW-1:0] r;
        for (int k = 0; k < NP; k++)
            r[64*k +: 64] = 64'(b[64*k +: 32]) * 64'(b[64*k+32 +: 32]);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                         input logic [BW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic drive(input int n, input int pct, input bit use_model,
                         input logic [BW-1:0] t0, input logic [BW-1:0] t1);
        for (int i = 0; i < n; i++) begin
            logic [BW-1:0] d;
            bit done;
            if (!use_model) d = (i == 0) ? t0 : t1;
            else for (int w = 0; w < BW/32; w++)
                d[32*w +: 32] = (($urandom_range(9) == 0) ? 32'hFFFFFFFF : $urandom);
            done = 1'b0;
            while (!done) begin
                @(negedge clk_fast);
                in_valid = ($urandom_range(99) < pct);
                in_data = d;
                #1;
                if (in_valid && in_ready) begin
                    done = 1'b1;
                    acc_cnt++;
                    if (use_model) begin
                        if (!have_pend) begin pend = d; have_pend = 1'b1; end
                        else begin
                            exp_q.push_back(model(pend));
                            exp_q.push_back(model(d));
                            have_pend = 1'b0;
                        end
                    end
                end else if (in_valid) stall_cnt++;
            end
        end
        @(negedge clk_fast);
        in_valid = 1'b0;
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 5000) begin
            @(negedge clk_fast);
            t++;
        end
        repeat (4) @(negedge clk_fast);
        check(exp_q.size() == 0 && !have_pend, req, BW'(exp_q.size()), '0);
    endtask

    // egress monitor
    initial begin
        bit prev_stall = 1'b0;
        logic [BW-1:0] prev_data = '0;
        forever begin
            @(negedge clk_fast);
            out_ready = (rdy_mode == 2) ? ($urandom_range(99) < 70) : (rdy_mode == 1);
            #1;
            if (rst_n && prev_stall)
                check(out_valid && out_data == prev_data, "R5", out_data, prev_data);
            prev_stall = rst_n && out_valid && !out_ready;
            prev_data = out_data;
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, out_data, '0);
                end else begin
                    logic [BW-1:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, cur_req, out_data, e);
                end
                out_cnt++;
                if (first_out < 0) first_out = cyc;
                last_out = cyc;
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk_fast);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [BW-1:0] tb0, tb1, e0, e1;
        // R1: reset state
        repeat (3) @(negedge clk_fast);
        #1;
        check(!in_ready, "R1", BW'(in_ready), '0);
        check(!out_valid, "R1", BW'(out_valid), '0);
        repeat (3) @(negedge clk_fast);
        #1;
        check(!in_ready && !out_valid, "R1", BW'({in_ready, out_valid}), '0);
        @(negedge clk_fast);
        rst_n = 1'b1;
        for (int t = 0; t < 20 && !in_ready; t++) begin
            @(negedge clk_fast);
            #1;
        end

        // R2, R3: corner-operand table, first beat holds pairs 0..3
        cur_req = "R2";
        for (int k = 0; k < 8; k++) begin
            if (k < NP) begin
                tb0[64*k +: 32] = VECS[k][127:96];
                tb0[64*k+32 +: 32] = VECS[k][95:64];
                e0[64*k +: 64] = VECS[k][63:0];
            end else begin
                tb1[64*(k-NP) +: 32] = VECS[k][127:96];
                tb1[64*(k-NP)+32 +: 32] = VECS[k][95:64];
                e1[64*(k-NP) +: 64] = VECS[k][63:0];
            end
        end
        exp_q.push_back(e0);
        exp_q.push_back(e1);
        rdy_mode = 1;
        drive(2, 100, 1'b0, tb0, tb1);
        wait_drain("R3");

        // R6: full rate
        cur_req = "R6";
        stall_cnt = 0; out_cnt = 0; first_out = -1;
        drive(40, 100, 1'b1, '0, '0);
        wait_drain("R6");
        check(stall_cnt == 0, "R6", BW'(stall_cnt), '0);
        check(out_cnt == 40, "R6", BW'(out_cnt), BW'(40));
        check(last_out - first_out + 1 == out_cnt, "R6", BW'(last_out - first_out + 1), BW'(out_cnt));

        // R7: backpressure
        cur_req = "R7";
        rdy_mode = 0;
        acc_cnt = 0;
        fork
            drive(20, 100, 1'b1, '0, '0);
            begin
                repeat (150) @(negedge clk_fast);
                #1;
                check(!in_ready, "R7", BW'(in_ready), '0);
                check(acc_cnt > 0 && acc_cnt <= 13, "R7", BW'(acc_cnt), BW'(13));
                rdy_mode = 1;
            end
        join
        wait_drain("R7");
        check(acc_cnt == 20, "R7", BW'(acc_cnt), BW'(20));

        // R4: random stalls both sides
        cur_req = "R4";
        rdy_mode = 2;
        out_cnt = 0;
        drive(200, 60, 1'b1, '0, '0);
        wait_drain("R4");
        check(out_cnt == 200, "R4", BW'(out_cnt), BW'(200));

        finish_run();
    end
endmodule